// File: doc/BRIEF.md
# Sync Word Hunter with Receive Byte Holder

This block sits behind a data demodulator that delivers recovered bits, each marked by a one-cycle strobe on the system clock. While armed, it compares the sixteen most recent bits against a programmable sync word. An exact match raises a frame-found pulse that lasts one bit period. The same event disarms the hunt. The bits that follow are packed into bytes, and each finished byte is held for the host, which shifts it out one bit per read strobe.

One active-low status output serves two purposes, chosen by a select input. With select 0 it shows the frame-found pulse. With select 1 it shows a byte-ready level. The disarm state is visible on an output so that the register interface can read it back. A host write of 0 re-arms the hunt and reloads the bit history with all ones. That write is refused while the frame-found pulse is active. A host write of 1 while armed starts continuous byte packing with no sync search. The sync word comes from two 8-bit host registers whose power-up contents are 0x1BA8.

Top module: `sync_word_rx`

## Requirements
- R1: After reset, `det_off` is 0 (hunt armed), `overrun` is 0, `rx_byte` is 0 and `stat_n` is 1 for either value of `flag_sel`.
- R2: While armed, a strobed bit that makes the 16-bit history (oldest bit in bit 15, newest in bit 0) exactly equal to `pattern` starts the frame-found pulse. With `flag_sel`=0, `stat_n` is 0 from the cycle after that strobe until the cycle after the next bit strobe, so it is low for one bit period. A history that differs from `pattern` in any bit starts no pulse.
- R3: A sync match sets `det_off` to 1 in the cycle after the matching strobe. While `det_off` is 1, no further match is reported.
- R4: A host write of 0 (`arm_wr`=1, `arm_val`=0) is ignored while the frame-found pulse is active. The same write made after the pulse ends clears `det_off`.
- R5: An accepted write of 0 reloads the bit history with all ones. A sync word whose upper bits are ones can therefore match fewer than 16 bits after re-arming.
- R6: While `det_off` is 1, the bits that follow the match are packed MSB first: the first bit lands in `rx_byte[7]`. After the eighth bit the byte is held in `rx_byte`, and with `flag_sel`=1 `stat_n` goes to 0.
- R7: While a byte is ready, `rd_bit` shows `rx_byte[7-k]` after k read strobes. After the eighth read strobe `stat_n` returns to 1 (with `flag_sel`=1).
- R8: A write of 1 while armed sets `det_off` and starts packing bytes from the next bit, with no sync search.
- R9: A byte that completes before the held byte is fully read overwrites `rx_byte` and sets `overrun`. `overrun` stays 1 until the next accepted re-arm write clears it.
- R10: When a byte completes in the same cycle as the eighth read strobe of the previous byte, the new byte is held, byte-ready stays set and `overrun` stays 0.
- R11: Read strobes while no byte is ready have no effect on the read position of the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | One-cycle strobe marking a recovered bit |
| bit_in | input | 1 | Recovered bit value, valid with `bit_valid` |
| pattern | input | 16 | Sync word, taken from two 8-bit host registers |
| flag_sel | input | 1 | Status source: 0 frame-found pulse, 1 byte-ready |
| arm_wr | input | 1 | Host write strobe for the disarm bit |
| arm_val | input | 1 | Value written: 0 re-arms the hunt, 1 selects continuous packing |
| rd_stb | input | 1 | Host read strobe, advances the read position by one bit |
| stat_n | output | 1 | Active-low status |
| det_off | output | 1 | Disarm state for readback |
| rx_byte | output | 8 | Held received byte |
| rd_bit | output | 1 | Current bit of the held byte, MSB first |
| overrun | output | 1 | Held byte was overwritten before it was fully read |

## Verification
Two functions can fall in the same cycle: a byte completing and the final read strobe of the previous byte. The bench sets this up by sending seven bits of a new byte and issuing seven read strobes. It then drives the eighth bit strobe and the eighth read strobe in the same cycle. The expected result is that the new byte is held, the status stays low and no overrun is flagged. A second collision is also exercised: a re-arm write landing while the frame-found pulse is active, where the write must be dropped.

// File: rtl/sync_word_rx_pkg.sv
package sync_word_rx_pkg;

  // Source shown on the shared active-low status output
  typedef enum logic {
    STAT_FRAME = 1'b0,
    STAT_BYTE  = 1'b1
  } stat_src_e;

  // Bit history contents after reset or re-arm: every node at 1
  function automatic logic [31:0] seed_ones(input int unsigned w);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < 32; i++) begin
      if (i < w) v[i] = 1'b1;
    end
    return v;
  endfunction

endpackage

// File: rtl/sw_hunt.sv
module sw_hunt #(
  parameter int PAT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_valid,
  input  logic             bit_in,
  input  logic             armed,
  input  logic             reseed,
  input  logic [PAT_W-1:0] pattern,
  output logic             hit
);
  import sync_word_rx_pkg::*;

  localparam logic [PAT_W-1:0] SEED = PAT_W'(seed_ones(PAT_W));

  logic [PAT_W-1:0] hist_q;
  logic [PAT_W-1:0] hist_nx;

  assign hist_nx = {hist_q[PAT_W-2:0], bit_in};
  assign hit     = armed && bit_valid && (hist_nx == pattern);

  always_ff @(posedge clk) begin
    if (rst || reseed) begin
      hist_q <= SEED;
    end else if (armed && bit_valid) begin
      hist_q <= hist_nx;
    end
  end

endmodule

// File: rtl/sw_ctrl.sv
module sw_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic hit,
  input  logic arm_wr,
  input  logic arm_val,
  output logic det_off,
  output logic fd_pulse,
  output logic rearm,
  output logic start_cont
);

  logic det_off_q;
  logic pulse_q;

  // Write of 0 is dropped while the frame-found pulse is active
  assign rearm      = arm_wr && !arm_val && !pulse_q && !hit;
  assign start_cont = arm_wr &&  arm_val && !det_off_q && !hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      det_off_q <= 1'b0;
    end else if (hit) begin
      det_off_q <= 1'b1;
    end else if (rearm) begin
      det_off_q <= 1'b0;
    end else if (start_cont) begin
      det_off_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
    end else if (hit) begin
      pulse_q <= 1'b1;
    end else if (bit_valid) begin
      pulse_q <= 1'b0;
    end
  end

  assign det_off  = det_off_q;
  assign fd_pulse = pulse_q;

endmodule

// File: rtl/sw_pack.sv
module sw_pack #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              collect,
  input  logic              bit_in,
  input  logic              restart,
  input  logic              rearm,
  input  logic              rd_stb,
  output logic [BYTE_W-1:0] hold,
  output logic              byte_rdy,
  output logic              overrun,
  output logic              rd_bit
);

  localparam int CW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  logic [BYTE_W-1:0] asm_q;
  logic [CW-1:0]     cnt_q;
  logic [BYTE_W-1:0] hold_q;
  logic              rdy_q;
  logic              ovr_q;
  logic [CW-1:0]     rd_cnt_q;
  logic              done;
  logic              last_rd;
  logic [BYTE_W-1:0] asm_nx;

  assign asm_nx  = {asm_q[BYTE_W-2:0], bit_in};
  assign done    = collect && (cnt_q == LAST);
  assign last_rd = rd_stb && rdy_q && (rd_cnt_q == LAST);

  // Assembly shift register and bit counter
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      asm_q <= '0;
      cnt_q <= '0;
    end else if (collect) begin
      asm_q <= asm_nx;
      cnt_q <= done ? '0 : cnt_q + 1'b1;
    end
  end

  // Holding register with host read position
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= '0;
      rdy_q    <= 1'b0;
      rd_cnt_q <= '0;
    end else if (rearm) begin
      rdy_q    <= 1'b0;
      rd_cnt_q <= '0;
    end else if (done) begin
      hold_q   <= asm_nx;
      rdy_q    <= 1'b1;
      rd_cnt_q <= '0;
    end else if (rd_stb && rdy_q) begin
      rd_cnt_q <= last_rd ? '0 : rd_cnt_q + 1'b1;
      if (last_rd) rdy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || rearm) begin
      ovr_q <= 1'b0;
    end else if (done && rdy_q && !last_rd) begin
      ovr_q <= 1'b1;
    end
  end

  assign hold     = hold_q;
  assign byte_rdy = rdy_q;
  assign overrun  = ovr_q;
  assign rd_bit   = hold_q[LAST - rd_cnt_q];

endmodule

// File: rtl/sync_word_rx.sv
module sync_word_rx #(
  parameter int BYTE_W = 8,
  parameter int PAT_W  = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_valid,
  input  logic              bit_in,
  input  logic [PAT_W-1:0]  pattern,
  input  logic              flag_sel,
  input  logic              arm_wr,
  input  logic              arm_val,
  input  logic              rd_stb,
  output logic              stat_n,
  output logic              det_off,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rd_bit,
  output logic              overrun
);
  import sync_word_rx_pkg::*;

  logic hit;
  logic fd_pulse;
  logic rearm;
  logic start_cont;
  logic byte_rdy;
  logic collect;
  stat_src_e src;

  sw_hunt #(.PAT_W(PAT_W)) hunt_i (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .armed(!det_off), .reseed(rearm), .pattern(pattern), .hit(hit)
  );

  sw_ctrl ctrl_i (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .hit(hit),
    .arm_wr(arm_wr), .arm_val(arm_val), .det_off(det_off),
    .fd_pulse(fd_pulse), .rearm(rearm), .start_cont(start_cont)
  );

  assign collect = det_off && bit_valid;

  sw_pack #(.BYTE_W(BYTE_W)) pack_i (
    .clk(clk), .rst(rst), .collect(collect), .bit_in(bit_in),
    .restart(hit || rearm || start_cont), .rearm(rearm), .rd_stb(rd_stb),
    .hold(rx_byte), .byte_rdy(byte_rdy), .overrun(overrun), .rd_bit(rd_bit)
  );

  assign src    = stat_src_e'(flag_sel);
  assign stat_n = (src == STAT_BYTE) ? !byte_rdy : !fd_pulse;

endmodule

// File: rtl/sync_word_rx_chk.sv
module sync_word_rx_chk (
  input logic clk,
  input logic rst,
  input logic bit_valid,
  input logic arm_wr,
  input logic arm_val,
  input logic rd_stb,
  input logic det_off,
  input logic fd_pulse,
  input logic byte_rdy,
  input logic overrun
);

  // R3
  pulse_disarms_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fd_pulse) |-> det_off);

  // R2
  pulse_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (fd_pulse && !bit_valid) |=> fd_pulse);

  // R2
  pulse_one_period_chk: assert property (@(posedge clk) disable iff (rst)
    (fd_pulse && bit_valid) |=> !fd_pulse);

  // R4
  rearm_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (fd_pulse && arm_wr && !arm_val) |=> det_off);

  // R7
  ready_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_rdy && !rd_stb && !arm_wr) |=> byte_rdy);

  // R9
  overrun_with_byte_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> byte_rdy);

endmodule

bind sync_word_rx sync_word_rx_chk chk_i (
  .clk(clk), .rst(rst), .bit_valid(bit_valid), .arm_wr(arm_wr),
  .arm_val(arm_val), .rd_stb(rd_stb), .det_off(det_off),
  .fd_pulse(fd_pulse), .byte_rdy(byte_rdy), .overrun(overrun)
);

// File: tb/sync_word_rx_tb.sv
module sync_word_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IDLE = 3;

  logic clk = 1'b0;
  logic rst, bit_valid, bit_in, flag_sel, arm_wr, arm_val, rd_stb;
  logic [15:0] pattern;
  logic stat_n, det_off, rd_bit, overrun;
  logic [7:0] rx_byte;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_word_rx dut_i (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .pattern(pattern), .flag_sel(flag_sel), .arm_wr(arm_wr),
    .arm_val(arm_val), .rd_stb(rd_stb), .stat_n(stat_n),
    .det_off(det_off), .rx_byte(rx_byte), .rd_bit(rd_bit),
    .overrun(overrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    bit_valid = 1'b1; bit_in = b;
    @(negedge clk);
    bit_valid = 1'b0;
    idle(IDLE);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic send_word(input logic [15:0] v);
    for (int i = 15; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic host_arm(input logic v);
    arm_wr = 1'b1; arm_val = v;
    @(negedge clk);
    arm_wr = 1'b0;
  endtask

  task automatic read_byte(input logic [7:0] exp, input int n, input string req);
    for (int k = 0; k < n; k++) begin
      chk(req, rd_bit, exp[7-k]);
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
    end
  endtask

  task automatic t_reset;
    chk("R1 det_off", det_off, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 rx_byte", rx_byte, 0);
    chk("R1 stat frame", stat_n, 1);
    flag_sel = 1'b1; #1;
    chk("R1 stat byte", stat_n, 1);
    flag_sel = 1'b0;
  endtask

  task automatic t_frame_hit;
    send_word(16'h1BA9);
    chk("R2 near miss", stat_n, 1);
    chk("R2 near miss armed", det_off, 0);
    for (int i = 15; i >= 1; i--) send_bit(pattern[i]);
    chk("R2 before last bit", stat_n, 1);
    bit_valid = 1'b1; bit_in = pattern[0];
    @(negedge clk);
    bit_valid = 1'b0;
    chk("R2 pulse low", stat_n, 0);
    chk("R3 disarmed", det_off, 1);
    host_arm(1'b0);
    chk("R4 write ignored", det_off, 1);
    idle(IDLE);
    chk("R2 pulse held", stat_n, 0);
    send_bit(1'b1);
    chk("R2 pulse ended", stat_n, 1);
    flag_sel = 1'b1;
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    chk("R6 not yet ready", stat_n, 1);
    send_bit(1'b1);
    chk("R6 byte ready", stat_n, 0);
    chk("R6 byte value", rx_byte, 8'hC5);
    chk("R3 no rehunt", det_off, 1);
    read_byte(8'hC5, 8, "R7 serial bit");
    chk("R7 flag released", stat_n, 1);
  endtask

  task automatic t_overrun;
    send_byte(8'h3C);
    chk("R9 first byte", rx_byte, 8'h3C);
    chk("R9 no overrun yet", overrun, 0);
    send_byte(8'h81);
    chk("R9 overwritten", rx_byte, 8'h81);
    chk("R9 overrun set", overrun, 1);
    read_byte(8'h81, 8, "R9 read new");
    chk("R9 overrun sticky", overrun, 1);
    host_arm(1'b0);
    chk("R9 overrun cleared", overrun, 0);
    chk("R4 rearm accepted", det_off, 0);
  endtask

  task automatic t_reseed;
    flag_sel = 1'b0;
    pattern = 16'hFFF0;
    host_arm(1'b1);
    host_arm(1'b0);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    chk("R5 three zeros", det_off, 0);
    send_bit(1'b0);
    chk("R5 seeded hit", stat_n, 0);
    chk("R5 seeded disarm", det_off, 1);
  endtask

  task automatic t_collision;
    flag_sel = 1'b1;
    send_byte(8'h5A);
    chk("R6 byte after reseed", rx_byte, 8'h5A);
    for (int i = 7; i >= 1; i--) send_bit(8'h96 >> i);
    read_byte(8'h5A, 7, "R10 partial read");
    bit_valid = 1'b1; bit_in = 1'b0; rd_stb = 1'b1;
    @(negedge clk);
    bit_valid = 1'b0; rd_stb = 1'b0;
    chk("R10 new byte", rx_byte, 8'h96);
    chk("R10 still ready", stat_n, 0);
    chk("R10 no overrun", overrun, 0);
    read_byte(8'h96, 8, "R10 read new");
    chk("R10 released", stat_n, 1);
  endtask

  task automatic t_continuous;
    pattern = 16'h1BA8;
    host_arm(1'b0);
    chk("R8 armed", det_off, 0);
    host_arm(1'b1);
    chk("R8 continuous", det_off, 1);
    send_byte(8'hE7);
    chk("R8 byte", rx_byte, 8'hE7);
    chk("R8 ready", stat_n, 0);
    read_byte(8'hE7, 8, "R8 read");
    rd_stb = 1'b1; idle(3); rd_stb = 1'b0;
    send_byte(8'h0F);
    read_byte(8'h0F, 8, "R11 read position");
    chk("R11 released", stat_n, 1);
  endtask

  initial begin
    rst = 1'b1; bit_valid = 1'b0; bit_in = 1'b0; flag_sel = 1'b0;
    arm_wr = 1'b0; arm_val = 1'b0; rd_stb = 1'b0; pattern = 16'h1BA8;
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_frame_hit();
    t_overrun();
    t_reseed();
    t_collision();
    t_continuous();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule